// File: doc/BRIEF.md
# Domain and Subpage Access Permission Checker

This block takes the result of a completed address translation and decides whether the memory access that caused it may go ahead. It first looks up a 2-bit mode for the mapping's domain in a 32-bit domain control word. A no-access or reserved mode denies the access with a domain fault. A manager mode grants it. A client mode passes the decision to a permission check.

The permission check uses a 2-bit permission code. For a section mapping, the code comes from a single field of the descriptor. For large and small pages, it comes from one of four subpage fields, picked by virtual address bits. For a tiny page, it comes from the lowest field. The code is then compared with the privilege and direction of the access, using the fixed system-protection table. The verdict is registered and appears with a one-cycle valid pulse one clock after the input strobe.

Top module: `perm_chk_top`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `res_vld`, `res_allow` and `res_fault` are all 0.
- R2: `res_vld` is high exactly in the cycle after an edge at which `req_vld` was high. The other outputs describe that request, and they hold their value while `res_vld` is low.
- R3: The mode of domain d is `dom_ctl[2d+1:2d]`. Mode 00 (no access) and mode 10 (reserved) deny the access with `res_fault` = 01 (domain fault).
- R4: Mode 11 (manager) allows every access with `res_fault` = 00, whatever the permission bits, privilege or direction.
- R5: Mode 01 (client) applies the permission code as follows:
  - 00: privileged read only.
  - 01: privileged read and write; user has no access.
  - 10: privileged read and write; user read only.
  - 11: read and write for everyone.
  A denial gives `res_fault` = 10 (permission fault).
- R6: For a section (`map_kind` = 00), the permission code is `desc_perm[11:10]`.
- R7: For a small page (`map_kind` = 10), the code is the field at bits [2k+5:2k+4], where k = `va_low[11:10]`.
- R8: For a large page (`map_kind` = 01), the code is the field at bits [2k+5:2k+4], where k = `va_low[15:14]`.
- R9: For a tiny page (`map_kind` = 11), the code is `desc_perm[5:4]`.
- R10: A domain fault takes priority over a permission fault. Whenever `res_allow` is 1, `res_fault` is 00; whenever `res_allow` is 0, `res_fault` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| dom_id | input | 4 | Domain number of the mapping |
| dom_ctl | input | 32 | Domain control word, 2 bits per domain |
| desc_perm | input | 12 | Descriptor bits [11:0] holding the permission fields |
| map_kind | input | 2 | 00 section, 01 large, 10 small, 11 tiny |
| va_low | input | 16 | Virtual address bits [15:0] |
| acc_user | input | 1 | 1 = user access, 0 = privileged |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_vld | output | 1 | Result valid, one cycle |
| res_allow | output | 1 | 1 = access granted |
| res_fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |

## Verification
Every verdict is due on the clock edge after the edge that sampled `req_vld`. The bench drives inputs on the falling edge, so they are in place for the next rising edge. It samples outputs on the falling edge that follows that rising edge, which gives each result exactly one registered stage. Idle cycles placed between requests check that `res_vld` drops and that the outputs hold.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;
  localparam int DOM_W   = 4;
  localparam int CTL_W   = 2 << DOM_W;
  localparam int PERM_W  = 12;
  localparam int VA_W    = 16;
  localparam int NSUB    = 4;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_CLNT = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_MGR  = 2'b11
  } dom_mode_e;

  typedef enum logic [1:0] {
    KIND_SECT  = 2'b00,
    KIND_LARGE = 2'b01,
    KIND_SMALL = 2'b10,
    KIND_TINY  = 2'b11
  } map_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_DOM  = 2'b01,
    FLT_PERM = 2'b10
  } fault_e;
endpackage

// File: rtl/perm_dom_dec.sv
module perm_dom_dec
  import perm_chk_pkg::*;
#(
  parameter int DW = DOM_W
) (
  input  logic [DW-1:0]       dom_id,
  input  logic [(2<<DW)-1:0]  dom_ctl,
  output dom_mode_e           mode
);
  localparam int NDOM = 1 << DW;
  logic [1:0] fld [NDOM];

  genvar g;
  generate
    for (g = 0; g < NDOM; g++) begin : g_dom
      assign fld[g] = dom_ctl[2*g+1 -: 2];
    end
  endgenerate

  always_comb begin
    mode = dom_mode_e'(fld[dom_id]);
  end
endmodule

// File: rtl/perm_sub_sel.sv
module perm_sub_sel
  import perm_chk_pkg::*;
#(
  parameter int PW = PERM_W,
  parameter int VW = VA_W
) (
  input  logic [PW-1:0] desc_perm,
  input  map_kind_e     kind,
  input  logic [VW-1:0] va_low,
  output logic [1:0]    ap
);
  logic [1:0] sub [NSUB];
  logic [1:0] idx;

  genvar g;
  generate
    for (g = 0; g < NSUB; g++) begin : g_sub
      assign sub[g] = desc_perm[2*g+5 -: 2];
    end
  endgenerate

  always_comb begin
    case (kind)
      KIND_SMALL: idx = va_low[11:10];
      KIND_LARGE: idx = va_low[15:14];
      KIND_SECT:  idx = 2'd3;
      default:    idx = 2'd0;
    endcase
    ap = sub[idx];
  end
endmodule

// File: rtl/perm_ap_eval.sv
module perm_ap_eval (
  input  logic [1:0] ap,
  input  logic       user,
  input  logic       write,
  output logic       ok
);
  always_comb begin
    case (ap)
      2'b00:   ok = !user && !write;
      2'b01:   ok = !user;
      2'b10:   ok = !user || !write;
      default: ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/perm_chk_top.sv
module perm_chk_top
  import perm_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_vld,
  input  logic [3:0]  dom_id,
  input  logic [31:0] dom_ctl,
  input  logic [11:0] desc_perm,
  input  logic [1:0]  map_kind,
  input  logic [15:0] va_low,
  input  logic        acc_user,
  input  logic        acc_write,
  output logic        res_vld,
  output logic        res_allow,
  output logic [1:0]  res_fault
);
  dom_mode_e  mode;
  logic [1:0] ap;
  logic       ap_ok;

  perm_dom_dec #(.DW(DOM_W)) u_dom (
    .dom_id (dom_id),
    .dom_ctl(dom_ctl),
    .mode   (mode)
  );

  perm_sub_sel #(.PW(PERM_W), .VW(VA_W)) u_sub (
    .desc_perm(desc_perm),
    .kind     (map_kind_e'(map_kind)),
    .va_low   (va_low),
    .ap       (ap)
  );

  perm_ap_eval u_ap (
    .ap   (ap),
    .user (acc_user),
    .write(acc_write),
    .ok   (ap_ok)
  );

  logic       allow_nxt;
  logic [1:0] fault_nxt;

  always_comb begin
    allow_nxt = 1'b0;
    fault_nxt = FLT_DOM;
    case (mode)
      MODE_MGR: begin
        allow_nxt = 1'b1;
        fault_nxt = FLT_NONE;
      end
      MODE_CLNT: begin
        allow_nxt = ap_ok;
        fault_nxt = ap_ok ? FLT_NONE : FLT_PERM;
      end
      default: begin
        allow_nxt = 1'b0;
        fault_nxt = FLT_DOM;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
    end else begin
      res_vld <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_allow <= 1'b0;
      res_fault <= FLT_NONE;
    end else if (req_vld) begin
      res_allow <= allow_nxt;
      res_fault <= fault_nxt;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld) else $error("vld"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(res_allow) && $stable(res_fault)) else $error("hold"); // R2
  AST_ALLOW_NOFLT: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_allow |-> res_fault == FLT_NONE) else $error("allow"); // R10
  AST_DENY_FLT: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !res_allow |-> res_fault != FLT_NONE) else $error("deny"); // R10
  AST_MGR_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && mode == MODE_MGR |=> res_allow) else $error("mgr"); // R4
  AST_BAD_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && (mode == MODE_NONE || mode == MODE_RSVD) |=> res_fault == FLT_DOM) else $error("dom"); // R3
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault != 2'b11) else $error("code"); // R10
endmodule

// File: tb/perm_chk_top_bench.sv
module perm_chk_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [3:0]  dom_id;
  logic [31:0] dom_ctl;
  logic [11:0] desc_perm;
  logic [1:0]  map_kind;
  logic [15:0] va_low;
  logic        acc_user, acc_write;
  logic        res_vld, res_allow;
  logic [1:0]  res_fault;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  perm_chk_top u_perm_chk_top (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .dom_id(dom_id),
    .dom_ctl(dom_ctl), .desc_perm(desc_perm), .map_kind(map_kind),
    .va_low(va_low), .acc_user(acc_user), .acc_write(acc_write),
    .res_vld(res_vld), .res_allow(res_allow), .res_fault(res_fault)
  );

  function automatic logic [2:0] model(input logic [3:0] d, input logic [31:0] c,
      input logic [11:0] p, input logic [1:0] k, input logic [15:0] v,
      input logic u, input logic w);
    logic [1:0] m, a, s;
    logic ok;
    m = c[2*d +: 2];
    if (m == 2'b00 || m == 2'b10) return 3'b0_01;
    if (m == 2'b11) return 3'b1_00;
    case (k)
      2'b00: s = 2'd3;
      2'b01: s = v[15:14];
      2'b10: s = v[11:10];
      default: s = 2'd0;
    endcase
    a = p[4 + 2*s +: 2];
    case (a)
      2'b00: ok = !u && !w;
      2'b01: ok = !u;
      2'b10: ok = !u || !w;
      default: ok = 1'b1;
    endcase
    return ok ? 3'b1_00 : 3'b0_10;
  endfunction

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] d, input logic [31:0] c,
      input logic [11:0] p, input logic [1:0] k, input logic [15:0] v,
      input logic u, input logic w);
    logic [2:0] e;
    e = model(d, c, p, k, v, u, w);
    @(negedge clk);
    req_vld = 1; dom_id = d; dom_ctl = c; desc_perm = p; map_kind = k;
    va_low = v; acc_user = u; acc_write = w;
    @(negedge clk);
    req_vld = 0;
    chk(req, {res_allow, res_fault}, e);
    chk("R2 vld", {2'b0, res_vld}, 3'b001);
    dom_ctl = ~c; desc_perm = ~p;
    @(negedge clk);
    chk("R2 hold", {res_vld, res_allow, res_fault}, {1'b0, e});
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 0; req_vld = 0; dom_id = 0; dom_ctl = 0; desc_perm = 0;
    map_kind = 0; va_low = 0; acc_user = 0; acc_write = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {res_vld, res_allow, res_fault}, 4'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after", {res_vld, res_allow, res_fault}, 4'b0);
    // R3 / R4: every mode on domain 9
    for (int m = 0; m < 4; m++)
      run(m == 3 ? "R4 mgr" : "R3 dom", 4'd9, 32'(m) << 18, 12'h000, 2'b00, 16'h0, 1, 1);
    // R5 R6 R9: section and tiny, all codes and access kinds
    for (int a = 0; a < 4; a++)
      for (int x = 0; x < 4; x++) begin
        run("R5 R6 sect", 4'd0, 32'h1, 12'(a) << 10, 2'b00, 16'h0, x[1], x[0]);
        run("R9 tiny", 4'd15, 32'h4000_0000, 12'(a) << 4, 2'b11, 16'hFFFF, x[1], x[0]);
      end
    // R7 R8: subpage selection, one field writable-by-all
    for (int s = 0; s < 4; s++) begin
      run("R7 small", 4'd3, 32'h40, 12'h3 << (4 + 2*s), 2'b10, 16'(s) << 10, 1, 1);
      run("R8 large", 4'd3, 32'h40, 12'h3 << (4 + 2*s), 2'b01, 16'(s) << 14, 1, 1);
    end
    // R10: reserved mode beats a failing permission
    run("R10 prio", 4'd2, 32'h20, 12'h000, 2'b00, 16'h0, 1, 1);
    // random mix
    for (int i = 0; i < 300; i++)
      run("R5 rand", 4'($urandom), $urandom, 12'($urandom), 2'($urandom),
          16'($urandom), 1'($urandom), 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule